// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-facing register set for a single DMA channel. Software uses a 32-bit register bus with a 12-bit byte offset to program a staged descriptor: a configuration word plus 64-bit byte count, destination and source values. It then owns the channel through a claim bit and launches a transfer with a run bit. The staged descriptor goes straight out to a separate transfer engine. On an accepted launch the block raises a one-cycle start pulse for that engine.

The engine reports back through a dedicated update port. Each update loads the read-only execution copies of the descriptor and can set the done and error flags or drop the run bit. Two interrupt lines, one for done and one for error, are each gated by their own enable bit.

Ownership rules decide whether a run request counts. A launch is only honoured on a channel that was already claimed before the write. Claim cannot be released while a run is in progress. Taking a fresh claim reloads the staged descriptor with defaults, including a size of 6 in both size fields.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every readable register returns 0, both interrupt lines are low and no start pulse is present.
- R2: A read request (bus_req=1, bus_we=0) returns its data on bus_rdata with bus_rvalid=1 in the next cycle. The control word at offset 0x000 holds claim (bit 0), run (bit 1), done enable (bit 14), error enable (bit 15), done (bit 30) and error (bit 31). All its other bits read 0.
- R3: A control write that raises claim from 0 to 1 clears the staged byte count, destination and source. It loads the staged configuration with 0x6600_0000, which is 6 in the write-size field (bits 27:24) and 6 in the read-size field (bits 31:28).
- R4: A control write with claim=0 while run is currently 1 leaves claim at 1.
- R5: A control write leaves run at 0 and emits no start pulse in two cases: the channel was unclaimed before the write, or the write releases claim while run was 0.
- R6: An accepted control write that takes run from 0 to 1 asserts run_start for exactly that cycle, sets run, and clears the done and error flags whatever values were written for them.
- R7: The staged configuration at 0x004 is a full 32-bit read/write word. The staged byte count, destination and source sit at 0x008, 0x010 and 0x018 as 64-bit values. Each has its low word at the base offset and its high word at base+4, and the two words are written independently.
- R8: The execution copies are read-only: configuration at 0x104, and byte count, destination and source at 0x108, 0x110 and 0x118 (low/high words at base and base+4). Bus writes to them have no effect.
- R9: When eng_upd=1 the block loads all execution copies from the eng_* inputs. It sets done if eng_done_set=1, sets error if eng_err_set=1 and clears run if eng_run_clr=1. These engine effects override a control write in the same cycle.
- R10: irq_done is high exactly when done enable and done are both set, and irq_err is high exactly when error enable and error are both set, each following the register contents with no added delay.
- R11: Reads of any unmapped or unaligned offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| eng_upd | input | 1 | Engine update strobe |
| eng_done_set | input | 1 | Set done flag on update |
| eng_err_set | input | 1 | Set error flag on update |
| eng_run_clr | input | 1 | Clear run bit on update |
| eng_cfg | input | 32 | Execution configuration value |
| eng_bytes | input | 64 | Execution byte count value |
| eng_dst | input | 64 | Execution destination value |
| eng_src | input | 64 | Execution source value |
| nxt_cfg | output | 32 | Staged configuration |
| nxt_bytes | output | 64 | Staged byte count |
| nxt_dst | output | 64 | Staged destination |
| nxt_src | output | 64 | Staged source |
| run_start | output | 1 | One-cycle launch pulse to the engine |
| irq_done | output | 1 | Done interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The hardest case to reach from the ports is a control write and an engine update landing in the same clock cycle. In that cycle the written done, error and run values must lose to the engine's. A dedicated task drives the bus write and the update strobe at the same falling edge, so both are seen at one rising edge. A second hard case is a relaunch while flags are set with the written flag bits at 1: the start must still clear them. The bench reaches it by leaving done set from an earlier update before writing run.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  localparam int WORD_W = 32;
  localparam int OFFS_W = 12;
  localparam int DESC_W = 64;
  localparam int NDESC  = 3;   // byte count, destination, source
  localparam int STRIDE = 8;

  // control word bit positions
  localparam int B_CLAIM   = 0;
  localparam int B_RUN     = 1;
  localparam int B_DONE_IE = 14;
  localparam int B_ERR_IE  = 15;
  localparam int B_DONE    = 30;
  localparam int B_ERR     = 31;

  // staged configuration size fields
  localparam int WSZ_LSB = 24;
  localparam int RSZ_LSB = 28;
  localparam logic [3:0] SZ_DEFAULT = 4'd6;

  // register offsets
  localparam logic [OFFS_W-1:0] OFF_CTRL   = 12'h000;
  localparam logic [OFFS_W-1:0] OFF_NCFG   = 12'h004;
  localparam logic [OFFS_W-1:0] OFF_NDESC0 = 12'h008;
  localparam logic [OFFS_W-1:0] OFF_XCFG   = 12'h104;
  localparam logic [OFFS_W-1:0] OFF_XDESC0 = 12'h108;

  typedef struct packed {
    logic err;
    logic done;
    logic err_ie;
    logic done_ie;
    logic run;
    logic claim;
  } ctl_t;

  function automatic logic [WORD_W-1:0] ctl_pack(ctl_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[B_CLAIM]   = c.claim;
    w[B_RUN]     = c.run;
    w[B_DONE_IE] = c.done_ie;
    w[B_ERR_IE]  = c.err_ie;
    w[B_DONE]    = c.done;
    w[B_ERR]     = c.err;
    return w;
  endfunction

  function automatic ctl_t ctl_unpack(logic [WORD_W-1:0] w);
    ctl_t c;
    c.claim   = w[B_CLAIM];
    c.run     = w[B_RUN];
    c.done_ie = w[B_DONE_IE];
    c.err_ie  = w[B_ERR_IE];
    c.done    = w[B_DONE];
    c.err     = w[B_ERR];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_default();
    logic [WORD_W-1:0] w;
    w = '0;
    w[WSZ_LSB +: 4] = SZ_DEFAULT;
    w[RSZ_LSB +: 4] = SZ_DEFAULT;
    return w;
  endfunction

endpackage

// File: rtl/dma_ctl_word.sv
module dma_ctl_word
  import dma_chan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_we,
  input  ctl_t wval,
  input  logic eng_upd,
  input  logic eng_done_set,
  input  logic eng_err_set,
  input  logic eng_run_clr,
  output ctl_t ctl_q,
  output logic claim_rise,
  output logic run_start,
  output logic irq_done,
  output logic irq_err
);

  ctl_t ctl_d;
  logic blocked;

  always_comb begin
    ctl_d      = ctl_q;
    claim_rise = 1'b0;
    run_start  = 1'b0;
    // gating: no prior claim, or release while idle
    blocked    = ~ctl_q.claim | (~ctl_q.run & ~wval.claim);
    if (ctl_we) begin
      claim_rise    = ~ctl_q.claim & wval.claim;
      ctl_d.claim   = wval.claim | ctl_q.run;
      ctl_d.run     = wval.run & ~blocked;
      ctl_d.done_ie = wval.done_ie;
      ctl_d.err_ie  = wval.err_ie;
      run_start     = ctl_d.run & ~ctl_q.run;
      ctl_d.done    = run_start ? 1'b0 : wval.done;
      ctl_d.err     = run_start ? 1'b0 : wval.err;
    end
    // engine effects override the bus
    if (eng_upd) begin
      if (eng_done_set) ctl_d.done = 1'b1;
      if (eng_err_set)  ctl_d.err  = 1'b1;
      if (eng_run_clr)  ctl_d.run  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign irq_done = ctl_q.done_ie & ctl_q.done;
  assign irq_err  = ctl_q.err_ie  & ctl_q.err;

endmodule

// File: rtl/dma_next_desc.sv
module dma_next_desc
  import dma_chan_pkg::*;
#(
  parameter int DW = DESC_W,
  parameter int ND = NDESC
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       cfg_we,
  input  logic [ND-1:0]              lo_we,
  input  logic [ND-1:0]              hi_we,
  input  logic [WORD_W-1:0]          wdata,
  output logic [WORD_W-1:0]          cfg_q,
  output logic [ND-1:0][DW-1:0]      desc_q
);

  localparam int HI_W = DW - WORD_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (clr)    cfg_q <= cfg_default();
    else if (cfg_we) cfg_q <= wdata;
  end

  for (genvar g = 0; g < ND; g++) begin : g_desc
    logic [DW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= '0;
      end else if (clr) begin
        r <= '0;
      end else begin
        if (lo_we[g]) r[WORD_W-1:0] <= wdata;
        if (hi_we[g]) r[DW-1:WORD_W] <= wdata[HI_W-1:0];
      end
    end
    assign desc_q[g] = r;
  end

endmodule

// File: rtl/dma_exec_shadow.sv
module dma_exec_shadow
  import dma_chan_pkg::*;
#(
  parameter int DW = DESC_W,
  parameter int ND = NDESC
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [WORD_W-1:0]     cfg_in,
  input  logic [ND-1:0][DW-1:0] desc_in,
  output logic [WORD_W-1:0]     cfg_q,
  output logic [ND-1:0][DW-1:0] desc_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      desc_q <= '0;
    end else if (load) begin
      cfg_q  <= cfg_in;
      desc_q <= desc_in;
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int DW = DESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [OFFS_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              eng_upd,
  input  logic              eng_done_set,
  input  logic              eng_err_set,
  input  logic              eng_run_clr,
  input  logic [WORD_W-1:0] eng_cfg,
  input  logic [DW-1:0]     eng_bytes,
  input  logic [DW-1:0]     eng_dst,
  input  logic [DW-1:0]     eng_src,
  output logic [WORD_W-1:0] nxt_cfg,
  output logic [DW-1:0]     nxt_bytes,
  output logic [DW-1:0]     nxt_dst,
  output logic [DW-1:0]     nxt_src,
  output logic              run_start,
  output logic              irq_done,
  output logic              irq_err
);

  localparam int ND = NDESC;

  logic wr, rd;
  logic ctl_we, ncfg_we, claim_rise;
  logic [ND-1:0] lo_we, hi_we;
  ctl_t ctl_q;
  logic [ND-1:0][DW-1:0] ndesc, xdesc, eng_desc;
  logic [WORD_W-1:0] xcfg, rd_word;

  assign wr      = bus_req & bus_we;
  assign rd      = bus_req & ~bus_we;
  assign ctl_we  = wr & (bus_addr == OFF_CTRL);
  assign ncfg_we = wr & (bus_addr == OFF_NCFG);

  for (genvar g = 0; g < ND; g++) begin : g_dec
    assign lo_we[g] = wr & (bus_addr == OFF_NDESC0 + OFFS_W'(g * STRIDE));
    assign hi_we[g] = wr & (bus_addr == OFF_NDESC0 + OFFS_W'(g * STRIDE + 4));
  end

  assign eng_desc = {eng_src, eng_dst, eng_bytes};

  dma_ctl_word u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_we       (ctl_we),
    .wval         (ctl_unpack(bus_wdata)),
    .eng_upd      (eng_upd),
    .eng_done_set (eng_done_set),
    .eng_err_set  (eng_err_set),
    .eng_run_clr  (eng_run_clr),
    .ctl_q        (ctl_q),
    .claim_rise   (claim_rise),
    .run_start    (run_start),
    .irq_done     (irq_done),
    .irq_err      (irq_err)
  );

  dma_next_desc #(.DW(DW), .ND(ND)) u_next (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (claim_rise),
    .cfg_we (ncfg_we),
    .lo_we  (lo_we),
    .hi_we  (hi_we),
    .wdata  (bus_wdata),
    .cfg_q  (nxt_cfg),
    .desc_q (ndesc)
  );

  dma_exec_shadow #(.DW(DW), .ND(ND)) u_exec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (eng_upd),
    .cfg_in  (eng_cfg),
    .desc_in (eng_desc),
    .cfg_q   (xcfg),
    .desc_q  (xdesc)
  );

  assign nxt_bytes = ndesc[0];
  assign nxt_dst   = ndesc[1];
  assign nxt_src   = ndesc[2];

  always_comb begin
    rd_word = '0;
    if (bus_addr == OFF_CTRL) rd_word = ctl_pack(ctl_q);
    if (bus_addr == OFF_NCFG) rd_word = nxt_cfg;
    if (bus_addr == OFF_XCFG) rd_word = xcfg;
    for (int i = 0; i < ND; i++) begin
      if (bus_addr == OFF_NDESC0 + OFFS_W'(i * STRIDE))
        rd_word = ndesc[i][WORD_W-1:0];
      if (bus_addr == OFF_NDESC0 + OFFS_W'(i * STRIDE + 4))
        rd_word = WORD_W'(ndesc[i][DW-1:WORD_W]);
      if (bus_addr == OFF_XDESC0 + OFFS_W'(i * STRIDE))
        rd_word = xdesc[i][WORD_W-1:0];
      if (bus_addr == OFF_XDESC0 + OFFS_W'(i * STRIDE + 4))
        rd_word = WORD_W'(xdesc[i][DW-1:WORD_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      if (rd) bus_rdata <= rd_word;
    end
  end

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_pkg::*;
#(
  parameter int DW = DESC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [OFFS_W-1:0] bus_addr,
  input logic              wr_claim,
  input logic              eng_upd,
  input logic              eng_done_set,
  input logic              run_start,
  input ctl_t              ctl,
  input logic [WORD_W-1:0] next_cfg,
  input logic [DW-1:0]     next_bytes,
  input logic [WORD_W-1:0] exec_cfg
);

  logic ctl_wr;
  assign ctl_wr = bus_req & bus_we & (bus_addr == OFF_CTRL);

  a_r3_claim_reloads_next: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl.claim) |-> (next_cfg == cfg_default()) && (next_bytes == '0));

  a_r4_claim_kept_while_running: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl.run && !wr_claim |=> ctl.claim);

  a_r5_no_start_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl.claim |-> !run_start);

  a_r5_run_low_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && !ctl.claim |=> !ctl.run);

  a_r6_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
    run_start && !eng_upd |=> ctl.run && !ctl.done && !ctl.err);

  a_r8_exec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_upd |=> $stable(exec_cfg));

  a_r9_engine_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    eng_upd && eng_done_set |=> ctl.done);

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .bus_addr     (bus_addr),
  .wr_claim     (bus_wdata[0]),
  .eng_upd      (eng_upd),
  .eng_done_set (eng_done_set),
  .run_start    (run_start),
  .ctl          (ctl_q),
  .next_cfg     (nxt_cfg),
  .next_bytes   (nxt_bytes),
  .exec_cfg     (xcfg)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        eng_upd = 1'b0, eng_done_set = 1'b0, eng_err_set = 1'b0, eng_run_clr = 1'b0;
  logic [31:0] eng_cfg = '0;
  logic [63:0] eng_bytes = '0, eng_dst = '0, eng_src = '0;
  logic [31:0] nxt_cfg;
  logic [63:0] nxt_bytes, nxt_dst, nxt_src;
  logic        run_start, irq_done, irq_err;

  int checks = 0;
  int errors = 0;
  logic last_start;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .eng_upd(eng_upd), .eng_done_set(eng_done_set), .eng_err_set(eng_err_set),
    .eng_run_clr(eng_run_clr), .eng_cfg(eng_cfg), .eng_bytes(eng_bytes),
    .eng_dst(eng_dst), .eng_src(eng_src),
    .nxt_cfg(nxt_cfg), .nxt_bytes(nxt_bytes), .nxt_dst(nxt_dst), .nxt_src(nxt_src),
    .run_start(run_start), .irq_done(irq_done), .irq_err(irq_err)
  );

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    #1 last_start = run_start;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
    chk({tag, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    chk(tag, bus_rdata, exp);
  endtask

  task automatic eng(logic d, logic e, logic rc, logic with_wr, logic [31:0] wd);
    @(negedge clk);
    eng_upd = 1'b1; eng_done_set = d; eng_err_set = e; eng_run_clr = rc;
    if (with_wr) begin
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h000; bus_wdata = wd;
    end
    @(negedge clk);
    eng_upd = 1'b0; eng_done_set = 1'b0; eng_err_set = 1'b0; eng_run_clr = 1'b0;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq_done", {31'd0, irq_done}, 32'd0);
    chk("R1 irq_err", {31'd0, irq_err}, 32'd0);
    chk("R1 run_start", {31'd0, run_start}, 32'd0);
    rd_chk("R1 ctrl", 12'h000, 32'h0);
    rd_chk("R1 next cfg", 12'h004, 32'h0);
    rd_chk("R1 exec bytes", 12'h108, 32'h0);
  endtask

  task automatic t_next_rw();
    wr(12'h004, 32'hA5A5_0F0C);
    wr(12'h008, 32'h1111_2222);
    wr(12'h00C, 32'h3333_4444);
    wr(12'h014, 32'hDEAD_BEEF);
    wr(12'h018, 32'h0000_1000);
    rd_chk("R7 cfg", 12'h004, 32'hA5A5_0F0C);
    rd_chk("R7 bytes lo", 12'h008, 32'h1111_2222);
    rd_chk("R7 bytes hi", 12'h00C, 32'h3333_4444);
    rd_chk("R7 dst lo", 12'h010, 32'h0);
    rd_chk("R7 dst hi", 12'h014, 32'hDEAD_BEEF);
    rd_chk("R7 src lo", 12'h018, 32'h0000_1000);
    chk("R7 nxt_dst port", nxt_dst[63:32], 32'hDEAD_BEEF);
  endtask

  task automatic t_unmapped();
    wr(12'h020, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    wr(12'h009, 32'hFFFF_FFFF);
    rd_chk("R11 read 0x020", 12'h020, 32'h0);
    rd_chk("R11 read 0x100", 12'h100, 32'h0);
    rd_chk("R11 read 0x00A", 12'h00A, 32'h0);
    rd_chk("R11 bytes intact", 12'h008, 32'h1111_2222);
  endtask

  task automatic t_gate();
    wr(12'h000, 32'h0000_0003);
    chk("R5 no start unclaimed", {31'd0, last_start}, 32'd0);
    rd_chk("R5 run forced low", 12'h000, 32'h0000_0001);
    rd_chk("R3 cfg default", 12'h004, 32'h6600_0000);
    rd_chk("R3 bytes lo cleared", 12'h008, 32'h0);
    rd_chk("R3 dst hi cleared", 12'h014, 32'h0);
    wr(12'h000, 32'h0000_0002);
    chk("R5 no start on release", {31'd0, last_start}, 32'd0);
    rd_chk("R5 release idle", 12'h000, 32'h0);
  endtask

  task automatic t_start();
    wr(12'h000, 32'h0000_0001);
    wr(12'h008, 32'h0000_0040);
    wr(12'h000, 32'h0F00_C003);
    chk("R6 start pulse", {31'd0, last_start}, 32'd1);
    chk("R6 pulse one cycle", {31'd0, run_start}, 32'd0);
    rd_chk("R2 ctrl fields only", 12'h000, 32'h0000_C003);
    chk("R7 nxt_bytes port", nxt_bytes[31:0], 32'h40);
  endtask

  task automatic t_hold();
    wr(12'h000, 32'h0000_C002);
    chk("R4 no restart", {31'd0, last_start}, 32'd0);
    rd_chk("R4 claim held", 12'h000, 32'h0000_C003);
  endtask

  task automatic t_engine();
    eng_cfg = 32'h6600_0004; eng_bytes = 64'h0;
    eng_dst = 64'h0000_0020_0000_0040; eng_src = 64'h1234_5678_9ABC_DEF0;
    eng(1'b1, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R10 irq_done on", {31'd0, irq_done}, 32'd1);
    chk("R10 irq_err off", {31'd0, irq_err}, 32'd0);
    rd_chk("R9 ctrl after done", 12'h000, 32'h4000_C001);
    rd_chk("R9 exec cfg", 12'h104, 32'h6600_0004);
    rd_chk("R9 exec src lo", 12'h118, 32'h9ABC_DEF0);
    rd_chk("R9 exec src hi", 12'h11C, 32'h1234_5678);
    rd_chk("R9 exec dst hi", 12'h114, 32'h0000_0020);
    rd_chk("R9 exec bytes", 12'h108, 32'h0);
  endtask

  task automatic t_exec_ro();
    wr(12'h118, 32'hFFFF_FFFF);
    wr(12'h104, 32'h0);
    wr(12'h10C, 32'h5555_5555);
    rd_chk("R8 src ro", 12'h118, 32'h9ABC_DEF0);
    rd_chk("R8 cfg ro", 12'h104, 32'h6600_0004);
    rd_chk("R8 bytes hi ro", 12'h10C, 32'h0);
  endtask

  task automatic t_err_irq();
    eng(1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
    chk("R10 irq_err on", {31'd0, irq_err}, 32'd1);
    rd_chk("R9 ctrl err", 12'h000, 32'hC000_C001);
    wr(12'h000, 32'hC000_0001);
    chk("R10 irq_done masked", {31'd0, irq_done}, 32'd0);
    chk("R10 irq_err masked", {31'd0, irq_err}, 32'd0);
    rd_chk("R10 flags kept", 12'h000, 32'hC000_0001);
  endtask

  task automatic t_priority();
    eng(1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_C001);
    rd_chk("R9 engine beats bus", 12'h000, 32'h4000_C001);
    chk("R9 irq_done after race", {31'd0, irq_done}, 32'd1);
  endtask

  task automatic t_restart();
    wr(12'h000, 32'hC000_C003);
    chk("R6 restart pulse", {31'd0, last_start}, 32'd1);
    chk("R6 irq cleared", {30'd0, irq_done, irq_err}, 32'd0);
    rd_chk("R6 flags cleared", 12'h000, 32'h0000_C003);
    wr(12'h000, 32'h0000_0000);
    rd_chk("R4 release refused", 12'h000, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_next_rw();
    t_unmapped();
    t_gate();
    t_start();
    t_hold();
    t_engine();
    t_exec_ro();
    t_err_irq();
    t_priority();
    t_restart();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule